// File: doc/BRIEF.md
# Cartridge Chip-Select Decoder with Ferroelectric-Safe Save Select

This block turns a handful of address-derived inputs, a cartridge-select strobe and a mapping-mode input into active-low chip selects. It drives a select for a single ROM, selects for the lower and upper halves of a two-ROM split, a select for an auxiliary device and a select for a save-memory chip. The whole block is combinational. An active-low reset and a digital supply-good flag qualify the outputs.

The save-memory select is built for a ferroelectric RAM. Such a part latches its address on a falling select edge, so it must see a new falling edge for every access. The decoded save select is therefore ORed with the AND of the active-low host read and write strobes. Between two bus accesses, when both strobes are high, the memory is deselected, even if the address stays in the save region.

Two mapping modes exist. In the low-mapping mode the four address inputs carry the upper bank bits, and ROM is chosen by one of them. In the high-mapping mode they carry lower page bits, and ROM is chosen by the cartridge strobe alone. Which address lines feed the four inputs is a board-level choice.

Top module: `cart_mem_decoder`

## Requirements
- R1: While `rst_n` is low, all five select outputs are high, whatever the other inputs are.
- R2: With `map_hi`=0 and `rst_n`=1, `rom_cs_n` is low exactly when `addr_bits[0]`=1 and `cart_sel_n`=0.
- R3: In both modes, whenever `rom_cs_n` is low, `rom_lo_cs_n` is low if `addr_bits[2]`=0 and `rom_hi_cs_n` is low if `addr_bits[2]`=1. Both are high whenever `rom_cs_n` is high.
- R4: With `map_hi`=0 and `rst_n`=1, `aux_cs_n` is low exactly when `cart_sel_n`=0 and `addr_bits`=4'b1100 (bit 0 is the first address input).
- R5: With `map_hi`=0 and `rst_n`=1, the decoded save select is active exactly when `cart_sel_n`=0, `addr_bits`=4'b1110 and `supply_ok`=1.
- R6: With `map_hi`=1 and `rst_n`=1, `rom_cs_n` is low exactly when `cart_sel_n`=0, for any value of `addr_bits`.
- R7: With `map_hi`=1 and `rst_n`=1, `aux_cs_n` is low exactly when `cart_sel_n`=1 and `addr_bits`=4'b0011.
- R8: With `map_hi`=1 and `rst_n`=1, the decoded save select is active exactly when `cart_sel_n`=1, `addr_bits`=4'b0111 and `supply_ok`=1.
- R9: `save_cs_n` equals the inverted decoded save select ORed with (`rd_n` AND `wr_n`). It is therefore high whenever neither strobe is low, and two back-to-back accesses to one save address give a high pulse between them.
- R10: Any input combination not covered by R2 to R8 leaves the corresponding selects high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_bits | input | 4 | Address-derived decode inputs; bit 0 is the first |
| cart_sel_n | input | 1 | Active-low cartridge-select strobe from the host |
| map_hi | input | 1 | Mapping mode: 0 low-mapping, 1 high-mapping |
| rst_n | input | 1 | Active-low reset; forces all selects high |
| supply_ok | input | 1 | High when main supply exceeds battery voltage |
| rd_n | input | 1 | Active-low host read strobe |
| wr_n | input | 1 | Active-low host write strobe |
| rom_cs_n | output | 1 | Active-low single-ROM select |
| rom_lo_cs_n | output | 1 | Active-low lower-ROM select |
| rom_hi_cs_n | output | 1 | Active-low upper-ROM select |
| aux_cs_n | output | 1 | Active-low auxiliary-device select |
| save_cs_n | output | 1 | Active-low save-memory select, strobe-gated |

## Verification
The block holds no state, so a wrong decode term appears at the ports in the same cycle in which the input combination that exercises it is applied. A term that is missing or inverted can hide behind a single address pattern, though. For that reason the whole input space is walked, and each output is compared separately. A broken strobe gate shows up only when both strobes are high while the address stays in the save region. The back-to-back access sequence is aimed at exactly that case.

// File: rtl/cart_sel_pkg.sv
package cart_sel_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic {
    MAP_LOW  = 1'b0,
    MAP_HIGH = 1'b1
  } map_mode_e;

  // Address-input bit roles (bit 0 = first address input)
  localparam int ROM_QUAL_BIT = 0;
  localparam int SPLIT_BIT    = 2;

  // Device patterns per mode
  localparam logic [ADDR_W-1:0] AUX_PAT_LOW   = 4'b1100;
  localparam logic [ADDR_W-1:0] SAVE_PAT_LOW  = 4'b1110;
  localparam logic [ADDR_W-1:0] AUX_PAT_HIGH  = 4'b0011;
  localparam logic [ADDR_W-1:0] SAVE_PAT_HIGH = 4'b0111;

  function automatic logic pat_hit(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] pat);
    return (a == pat);
  endfunction

  // Cartridge strobe level required for device region per mode
  function automatic logic dev_strobe_ok(input map_mode_e m, input logic cart_n);
    return (m == MAP_HIGH) ? cart_n : ~cart_n;
  endfunction

  // Idle bus: neither strobe asserted
  function automatic logic bus_idle(input logic rd_n, input logic wr_n);
    return rd_n & wr_n;
  endfunction

endpackage

// File: rtl/cart_rom_decode.sv
module cart_rom_decode
  import cart_sel_pkg::*;
#(
  parameter int AW        = ADDR_W,
  parameter int QUAL_BIT  = ROM_QUAL_BIT,
  parameter int SPL_BIT   = SPLIT_BIT
) (
  input  logic [AW-1:0] addr,
  input  logic          cart_n,
  input  map_mode_e     mode,
  input  logic          enable,
  output logic          rom_hit,
  output logic          lo_hit,
  output logic          hi_hit
);

  logic addr_qual;

  always_comb begin
    addr_qual = (mode == MAP_HIGH) ? 1'b1 : addr[QUAL_BIT];
    rom_hit   = enable & ~cart_n & addr_qual;
    lo_hit    = rom_hit & ~addr[SPL_BIT];
    hi_hit    = rom_hit &  addr[SPL_BIT];
  end

endmodule

// File: rtl/cart_dev_decode.sv
module cart_dev_decode
  import cart_sel_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic          cart_n,
  input  map_mode_e     mode,
  input  logic          enable,
  input  logic          supply_ok,
  output logic          aux_hit,
  output logic          save_hit
);

  logic [AW-1:0] aux_pat;
  logic [AW-1:0] save_pat;
  logic          strobe_ok;

  always_comb begin
    aux_pat   = (mode == MAP_HIGH) ? AUX_PAT_HIGH  : AUX_PAT_LOW;
    save_pat  = (mode == MAP_HIGH) ? SAVE_PAT_HIGH : SAVE_PAT_LOW;
    strobe_ok = dev_strobe_ok(mode, cart_n);
    aux_hit   = enable & strobe_ok & pat_hit(addr, aux_pat);
    save_hit  = enable & strobe_ok & supply_ok & pat_hit(addr, save_pat);
  end

endmodule

// File: rtl/cart_fram_gate.sv
module cart_fram_gate
  import cart_sel_pkg::*;
#(
  parameter bit GATE_ON_IDLE = 1'b1
) (
  input  logic save_hit,
  input  logic rd_n,
  input  logic wr_n,
  output logic cs_n
);

  generate
    if (GATE_ON_IDLE) begin : g_gated
      always_comb cs_n = ~save_hit | bus_idle(rd_n, wr_n);
    end else begin : g_plain
      always_comb cs_n = ~save_hit;
    end
  endgenerate

endmodule

// File: rtl/cart_mem_decoder.sv
module cart_mem_decoder
  import cart_sel_pkg::*;
#(
  parameter bit FRAM_SAFE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_bits,
  input  logic              cart_sel_n,
  input  logic              map_hi,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              rom_cs_n,
  output logic              rom_lo_cs_n,
  output logic              rom_hi_cs_n,
  output logic              aux_cs_n,
  output logic              save_cs_n
);

  map_mode_e mode;
  logic      rom_hit, lo_hit, hi_hit;
  logic      aux_hit, save_hit;

  assign mode = map_mode_e'(map_hi);

  cart_rom_decode u_rom (
    .addr    (addr_bits),
    .cart_n  (cart_sel_n),
    .mode    (mode),
    .enable  (rst_n),
    .rom_hit (rom_hit),
    .lo_hit  (lo_hit),
    .hi_hit  (hi_hit)
  );

  cart_dev_decode u_dev (
    .addr      (addr_bits),
    .cart_n    (cart_sel_n),
    .mode      (mode),
    .enable    (rst_n),
    .supply_ok (supply_ok),
    .aux_hit   (aux_hit),
    .save_hit  (save_hit)
  );

  cart_fram_gate #(.GATE_ON_IDLE(FRAM_SAFE)) u_gate (
    .save_hit (save_hit),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .cs_n     (save_cs_n)
  );

  assign rom_cs_n    = ~rom_hit;
  assign rom_lo_cs_n = ~lo_hit;
  assign rom_hi_cs_n = ~hi_hit;
  assign aux_cs_n    = ~aux_hit;

endmodule

// File: rtl/cart_mem_decoder_chk.sv
module cart_mem_decoder_chk (
  input logic rst_n,
  input logic supply_ok,
  input logic rd_n,
  input logic wr_n,
  input logic rom_cs_n,
  input logic rom_lo_cs_n,
  input logic rom_hi_cs_n,
  input logic aux_cs_n,
  input logic save_cs_n,
  input logic save_hit
);

  always_comb begin
    // R1
    p_reset_quiet_r1: assert (rst_n ||
      (rom_cs_n && rom_lo_cs_n && rom_hi_cs_n && aux_cs_n && save_cs_n))
      else $error("reset did not hold selects high");
    // R3
    p_split_onehot_r3: assert ($onehot0({~rom_lo_cs_n, ~rom_hi_cs_n}))
      else $error("both ROM halves selected");
    p_split_needs_rom_r3: assert (rom_cs_n == (rom_lo_cs_n && rom_hi_cs_n))
      else $error("ROM half select disagrees with ROM select");
    // R9
    p_idle_deselect_r9: assert (!(rd_n && wr_n) || save_cs_n)
      else $error("save select active on idle bus");
    p_gate_follows_decode_r9: assert (save_cs_n || save_hit)
      else $error("save select active without decode");
    // R8 / R5
    p_supply_gate_r8: assert (supply_ok || save_cs_n)
      else $error("save select active with supply low");
    // R10
    p_aux_save_excl_r10: assert (!(!aux_cs_n && save_hit))
      else $error("aux and save decoded together");
  end

endmodule

bind cart_mem_decoder cart_mem_decoder_chk u_chk (
  .rst_n       (rst_n),
  .supply_ok   (supply_ok),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .rom_cs_n    (rom_cs_n),
  .rom_lo_cs_n (rom_lo_cs_n),
  .rom_hi_cs_n (rom_hi_cs_n),
  .aux_cs_n    (aux_cs_n),
  .save_cs_n   (save_cs_n),
  .save_hit    (save_hit)
);

// File: tb/cart_mem_decoder_tb.sv
module cart_mem_decoder_tb;

  logic       clk = 1'b0;
  logic [3:0] addr_bits = 4'd0;
  logic       cart_sel_n = 1'b1, map_hi = 1'b0, rst_n = 1'b0;
  logic       supply_ok = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic       rom_cs_n, rom_lo_cs_n, rom_hi_cs_n, aux_cs_n, save_cs_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cart_mem_decoder u_dut (
    .addr_bits   (addr_bits),
    .cart_sel_n  (cart_sel_n),
    .map_hi      (map_hi),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .rom_cs_n    (rom_cs_n),
    .rom_lo_cs_n (rom_lo_cs_n),
    .rom_hi_cs_n (rom_hi_cs_n),
    .aux_cs_n    (aux_cs_n),
    .save_cs_n   (save_cs_n)
  );

  // Directed vectors: {addr[3:0], cart_n, map_hi, rst_n, supply_ok, rd_n, wr_n, exp{rom,lo,hi,aux,save}}
  localparam int NVEC = 10;
  localparam logic [14:0] VEC [NVEC] = '{
    {4'b1110, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'b11110}, // R5 save low-map, read
    {4'b1110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'b11111}, // R5 supply lost
    {4'b1100, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 5'b11101}, // R4 aux low-map
    {4'b0111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'b11110}, // R8 save high-map, write
    {4'b0011, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'b11101}, // R7 aux high-map
    {4'b0111, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'b01011}, // R6 + R3 upper half
    {4'b0001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 5'b00111}, // R2 + R3 lower half
    {4'b0111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'b11111}, // R9 idle bus
    {4'b1010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'b11111}, // R10 unlisted
    {4'b0111, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'b11111}  // R1 reset
  };

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (addr=%b cart_n=%b map=%b rst_n=%b ok=%b rd_n=%b wr_n=%b)",
               what, act, exp, addr_bits, cart_sel_n, map_hi, rst_n, supply_ok, rd_n, wr_n);
    end
  endtask

  // Independent reference, expressed as active-high enables per mode
  function automatic logic [4:0] ref_sel(input logic [3:0] a, input logic c, input logic m,
                                         input logic r, input logic s, input logic rd,
                                         input logic wr);
    logic rom, aux, sav;
    if (!r) return 5'b11111;
    case (m)
      1'b0: begin
        rom = (a[0] == 1'b1) && (c == 1'b0);
        aux = (c == 1'b0) && (a == 4'hC);
        sav = (c == 1'b0) && (a == 4'hE) && s;
      end
      default: begin
        rom = (c == 1'b0);
        aux = (c == 1'b1) && (a == 4'h3);
        sav = (c == 1'b1) && (a == 4'h7) && s;
      end
    endcase
    if (rd && wr) sav = 1'b0;
    return {!rom, !(rom && !a[2]), !(rom && a[2]), !aux, !sav};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] exp;
    // Reset state (R1)
    @(negedge clk); #1;
    check(rom_cs_n & rom_lo_cs_n & rom_hi_cs_n & aux_cs_n & save_cs_n, 1'b1, "R1 reset state");

    // Directed table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {addr_bits, cart_sel_n, map_hi, rst_n, supply_ok, rd_n, wr_n} = VEC[v][14:5];
      #1;
      check(rom_cs_n,    VEC[v][4], $sformatf("table[%0d] rom", v));
      check(rom_lo_cs_n, VEC[v][3], $sformatf("table[%0d] lo", v));
      check(rom_hi_cs_n, VEC[v][2], $sformatf("table[%0d] hi", v));
      check(aux_cs_n,    VEC[v][1], $sformatf("table[%0d] aux", v));
      check(save_cs_n,   VEC[v][0], $sformatf("table[%0d] save", v));
    end

    // Exhaustive walk of all 1024 input combinations
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      {addr_bits, cart_sel_n, map_hi, rst_n, supply_ok, rd_n, wr_n} = i[9:0];
      #1;
      exp = ref_sel(addr_bits, cart_sel_n, map_hi, rst_n, supply_ok, rd_n, wr_n);
      if (!rst_n) begin
        check(rom_cs_n & rom_lo_cs_n & rom_hi_cs_n & aux_cs_n & save_cs_n, 1'b1, "R1 reset gating");
      end else begin
        check(rom_cs_n, exp[4], map_hi ? "R6 rom select" : "R2 rom select");
        check(rom_lo_cs_n, exp[3], "R3 lower half");
        check(rom_hi_cs_n, exp[2], "R3 upper half");
        check(aux_cs_n, exp[1], map_hi ? "R7 aux select" : "R4 aux select");
        if (rd_n && wr_n) check(save_cs_n, exp[0], "R9 idle deselect");
        else check(save_cs_n, exp[0], map_hi ? "R8 save select" : "R5 save select");
      end
    end

    // Back-to-back reads of one save address (R9)
    @(negedge clk);
    addr_bits = 4'b0111; cart_sel_n = 1'b1; map_hi = 1'b1; rst_n = 1'b1;
    supply_ok = 1'b1; rd_n = 1'b0; wr_n = 1'b1;
    #1 check(save_cs_n, 1'b0, "R9 first access");
    @(negedge clk); rd_n = 1'b1;
    #1 check(save_cs_n, 1'b1, "R9 gap pulse");
    @(negedge clk); rd_n = 1'b0;
    #1 check(save_cs_n, 1'b0, "R9 second access");
    // Write then read back-to-back in low mapping
    @(negedge clk);
    addr_bits = 4'b1110; cart_sel_n = 1'b0; map_hi = 1'b0; rd_n = 1'b1; wr_n = 1'b0;
    #1 check(save_cs_n, 1'b0, "R9 write access");
    @(negedge clk); wr_n = 1'b1;
    #1 check(save_cs_n, 1'b1, "R9 gap after write");
    @(negedge clk); rd_n = 1'b0;
    #1 check(save_cs_n, 1'b0, "R9 read after write");

    // Reset asserted mid-access (R1)
    @(negedge clk); rst_n = 1'b0;
    #1 check(save_cs_n & rom_cs_n, 1'b1, "R1 reset mid-access");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule